// File: doc/BRIEF.md
# LCD status interrupt line generator

This block produces the single status-interrupt request of a handheld-console pixel processor. Four sources can feed it: horizontal blank, vertical blank, object scan and a line-compare match. Each source has an enable bit in a status register that the CPU writes. An enabled source whose condition is true drives a shared internal line high. A request is issued only when that line rises from low to high. While one source holds the line high, no other source can cause a new request.

The line-compare match is a registered compare of the line counter against the compare register, so it is seen one cycle late. When the older console variant is selected, every write to the status register makes all four enables act as set for the single cycle after the write. The written value applies from the following cycle on. If the line was low and any condition was true in that cycle, this gives a spurious request.

The request output is a registered one-cycle pulse. The status readback is plain combinational state and needs no handshake. Mode sequencing and line counting are done outside the block, which only samples them.

Top module: `lcd_stat_irq`

## Requirements
- R1: After reset `irq_o` is 0, all four enables are 0 and the match flag is 0, so `rd_data_o` reads `{1, 0000, 0, mode_i}`.
- R2: `irq_o` is high for exactly one cycle, in the cycle after the clock edge at which the combined line first evaluates high. The combined line is the OR of (enable AND condition) over the four sources, and it is evaluated at every edge from the enables and inputs present before that edge.
- R3: While the combined line stays high, a source that becomes enabled or active raises no further request.
- R4: With all four sources enabled, only pixel-transfer mode (mode 3) can drop the line. A later object-scan phase then raises a request. If the match flag stays set through mode 3, the line never drops and no request follows.
- R5: The match flag is updated at each edge to (display enabled AND `line_i == cmp_i`). It is readable on `rd_data_o[2]`, and a match-only request comes one cycle after the compare inputs become equal.
- R6: An enabled horizontal blank that holds the line high blocks the request of the object scan that follows it.
- R7: With `legacy_i` = 1 and the display on, a write makes all enables act as 1 for the cycle after the write. A true condition in that cycle with the line low gives a request, even when 0x00 is written.
- R8: The forced-enable cycle gives no request if the line is already high, or in mode 3 with the match flag clear.
- R9: Field layout: bit 3 enables horizontal blank (mode 0), bit 4 vertical blank (mode 1), bit 5 object scan (mode 2), bit 6 line match. Readback is bit 7 = 1, bits 6:3 = the stored enables, bit 2 = match flag, bits 1:0 = `mode_i`. Writing 0x10 enables only vertical blank, and writing 0x78 enables all four.
- R10: With `disp_en_i` = 0 every condition is inactive, the match flag is 0 and no request is raised.
- R11: With `legacy_i` = 0 a write has no forcing effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Display mode: 0 hblank, 1 vblank, 2 object scan, 3 transfer |
| line_i | input | LINE_W | Current line counter |
| cmp_i | input | LINE_W | Line-compare value |
| disp_en_i | input | 1 | Display enabled |
| legacy_i | input | 1 | Older console variant (forced-enable writes) |
| wr_en_i | input | 1 | Status register write strobe |
| wr_data_i | input | 8 | Status register write data |
| rd_data_o | output | 8 | Status register readback |
| irq_o | output | 1 | One-cycle status interrupt request |

## Verification
The bound checker watches several properties on every cycle:
- the request is never wider than one cycle;
- a request is only ever issued from a low line;
- the display-off gating holds;
- the match flag follows the compare one cycle late;
- written enables appear in the readback.

Blocking between sources, the pixel-transfer release and the forced-enable write on the older variant depend on sequences of modes and writes. Only the bench's scenarios and its cycle-by-cycle reference model can show these.

// File: rtl/lcd_stat_pkg.sv
package lcd_stat_pkg;
  localparam int NUM_SRC  = 4;
  localparam int REG_W    = 8;
  localparam int EN_LSB   = 3;
  localparam int EN_MSB   = EN_LSB + NUM_SRC - 1;

  typedef enum logic [1:0] {
    MODE_HBLANK = 2'd0,
    MODE_VBLANK = 2'd1,
    MODE_OSCAN  = 2'd2,
    MODE_XFER   = 2'd3
  } lcd_mode_e;

  // source index order: 0 hblank, 1 vblank, 2 object scan, 3 line match
  typedef enum int {
    SRC_HBLANK = 0,
    SRC_VBLANK = 1,
    SRC_OSCAN  = 2,
    SRC_MATCH  = 3
  } src_idx_e;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/stat_enable_reg.sv
module stat_enable_reg
  import lcd_stat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  src_vec_t wr_en_bits,
  input  logic     legacy,
  input  logic     disp_en,
  output src_vec_t en_stored,
  output src_vec_t en_eff
);
  src_vec_t en_q;
  logic     force_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      force_q <= 1'b0;
    end else begin
      force_q <= wr_en && legacy && disp_en;
      if (wr_en) en_q <= wr_en_bits;
    end
  end

  assign en_stored = en_q;
  assign en_eff    = force_q ? '1 : en_q;
endmodule

// File: rtl/stat_cond.sv
module stat_cond
  import lcd_stat_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [LINE_W-1:0] line,
  input  logic [LINE_W-1:0] cmp,
  input  logic              disp_en,
  output src_vec_t          cond,
  output logic              match
);
  logic      match_q;
  lcd_mode_e mode_e;

  assign mode_e = lcd_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= disp_en && (line == cmp);
  end

  always_comb begin
    cond = '0;
    if (disp_en) begin
      cond[SRC_HBLANK] = (mode_e == MODE_HBLANK);
      cond[SRC_VBLANK] = (mode_e == MODE_VBLANK);
      cond[SRC_OSCAN]  = (mode_e == MODE_OSCAN);
      cond[SRC_MATCH]  = match_q;
    end
  end

  assign match = match_q;
endmodule

// File: rtl/stat_edge.sv
module stat_edge
  import lcd_stat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     disp_en,
  input  src_vec_t en_eff,
  input  src_vec_t cond,
  output logic     line_hi,
  output logic     irq
);
  src_vec_t term;
  logic     comb_line;
  logic     line_q;
  logic     irq_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_term
    assign term[s] = en_eff[s] & cond[s];
  end

  assign comb_line = disp_en && (|term);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      line_q <= comb_line;
      irq_q  <= comb_line && !line_q;
    end
  end

  assign line_hi = line_q;
  assign irq     = irq_q;
endmodule

// File: rtl/lcd_stat_irq.sv
module lcd_stat_irq
  import lcd_stat_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] cmp_i,
  input  logic              disp_en_i,
  input  logic              legacy_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_o
);
  src_vec_t en_stored;
  src_vec_t en_eff;
  src_vec_t cond;
  logic     match;
  logic     line_hi;
  logic     unused_wr_bits;

  assign unused_wr_bits = ^{wr_data_i[REG_W-1], wr_data_i[EN_LSB-1:0]};

  stat_enable_reg u_en (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en_i),
    .wr_en_bits (wr_data_i[EN_MSB:EN_LSB]),
    .legacy     (legacy_i),
    .disp_en    (disp_en_i),
    .en_stored  (en_stored),
    .en_eff     (en_eff)
  );

  stat_cond #(.LINE_W(LINE_W)) u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_i),
    .line    (line_i),
    .cmp     (cmp_i),
    .disp_en (disp_en_i),
    .cond    (cond),
    .match   (match)
  );

  stat_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .disp_en (disp_en_i),
    .en_eff  (en_eff),
    .cond    (cond),
    .line_hi (line_hi),
    .irq     (irq_o)
  );

  assign rd_data_o = {1'b1, en_stored, match, mode_i};
endmodule

// File: rtl/lcd_stat_irq_chk.sv
module lcd_stat_irq_chk #(
  parameter int LINE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disp_en_i,
  input logic [LINE_W-1:0] line_i,
  input logic [LINE_W-1:0] cmp_i,
  input logic              wr_en_i,
  input logic [7:0]        wr_data_i,
  input logic [7:0]        rd_data_o,
  input logic              line_hi,
  input logic              irq_o
);
  assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_low_before_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_hi) |-> irq_o);

  assert_no_req_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_hi && !$rose(line_hi)) |-> !irq_o);

  assert_match_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en_i && line_i == cmp_i) |=> rd_data_o[2]);

  assert_match_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_en_i && line_i == cmp_i) |=> !rd_data_o[2]);

  assert_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> rd_data_o[6:3] == $past(wr_data_i[6:3]));

  assert_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en_i |=> !irq_o);
endmodule

bind lcd_stat_irq lcd_stat_irq_chk #(.LINE_W(LINE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .disp_en_i (disp_en_i),
  .line_i    (line_i),
  .cmp_i     (cmp_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .line_hi   (line_hi),
  .irq_o     (irq_o)
);

// File: tb/lcd_stat_irq_bench.sv
`timescale 1ns/100ps
module lcd_stat_irq_bench;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_i = 2'd3;
  logic [LW-1:0] line_i = '0;
  logic [LW-1:0] cmp_i = 8'd100;
  logic          disp_en_i = 1'b1;
  logic          legacy_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [7:0]    wr_data_i = '0;
  logic [7:0]    rd_data_o;
  logic          irq_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcd_stat_irq #(.LINE_W(LW)) u_lcd_stat_irq (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .line_i(line_i), .cmp_i(cmp_i),
    .disp_en_i(disp_en_i), .legacy_i(legacy_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: integers, evaluated on each rising edge
  int m_en = 0, m_force = 0, m_match = 0, m_line = 0, m_irq = 0;
  always @(posedge clk) begin
    int cond, eff, hit, nx_en, nx_force, nx_match;
    cycles++;
    if (!rst_n) begin
      m_en = 0; m_force = 0; m_match = 0; m_line = 0; m_irq = 0;
    end else begin
      cond = 0;
      if (disp_en_i) begin
        if (mode_i == 0) cond += 1;
        if (mode_i == 1) cond += 2;
        if (mode_i == 2) cond += 4;
        if (m_match != 0) cond += 8;
      end
      eff = (m_force != 0) ? 15 : m_en;
      hit = (disp_en_i && ((eff & cond) != 0)) ? 1 : 0;
      nx_match = (disp_en_i && line_i == cmp_i) ? 1 : 0;
      nx_force = (wr_en_i && legacy_i && disp_en_i) ? 1 : 0;
      nx_en    = wr_en_i ? int'(wr_data_i[6:3]) : m_en;
      m_irq = (hit == 1 && m_line == 0) ? 1 : 0;
      m_line = hit;
      m_match = nx_match; m_force = nx_force; m_en = nx_en;
    end
    #1;
    if (rst_n && !done) begin
      chk("R2 model irq", {7'd0, irq_o}, 8'(m_irq));
      chk("R9 model readback", rd_data_o,
          {1'b1, 4'(m_en), 1'(m_match), mode_i});
    end
    if (cycles > 5000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1.5;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    chk("R1 readback", rd_data_o, 8'h83);

    wr(8'h10);
    chk("R9 vblank-only readback", rd_data_o, 8'h93);
    chk("R11 no forced request", {7'd0, irq_o}, 8'h00);
    mode_i = 2'd1; tick();
    chk("R2 request on rise", {7'd0, irq_o}, 8'h01);
    tick();
    chk("R2 one-cycle pulse", {7'd0, irq_o}, 8'h00);

    wr(8'h78); tick();
    chk("R3 held line", {7'd0, irq_o}, 8'h00);
    chk("R9 all-enable readback", rd_data_o, 8'hF9);
    mode_i = 2'd0; tick();
    chk("R3 hblank while high", {7'd0, irq_o}, 8'h00);
    mode_i = 2'd2; tick();
    chk("R6 oscan blocked by hblank", {7'd0, irq_o}, 8'h00);
    mode_i = 2'd3; tick();
    mode_i = 2'd2; tick();
    chk("R4 request after transfer drop", {7'd0, irq_o}, 8'h01);

    line_i = 8'd5; cmp_i = 8'd5; tick();
    chk("R5 match flag", {7'd0, rd_data_o[2]}, 8'h01);
    mode_i = 2'd3;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R4 match holds through transfer", {7'd0, irq_o}, 8'h00);
    end
    mode_i = 2'd0; tick();
    chk("R4 no request after held line", {7'd0, irq_o}, 8'h00);

    legacy_i = 1'b1;
    wr(8'h78);
    chk("R8 forced write while high", {7'd0, irq_o}, 8'h00);
    tick();
    chk("R8 forced write while high", {7'd0, irq_o}, 8'h00);
    line_i = 8'd7; mode_i = 2'd3; tick(); tick();
    wr(8'h00); tick();
    chk("R8 forced write in transfer", {7'd0, irq_o}, 8'h00);

    mode_i = 2'd1; tick();
    chk("R7 quiet before write", {7'd0, irq_o}, 8'h00);
    wr(8'h00); tick();
    chk("R7 spurious request", {7'd0, irq_o}, 8'h01);
    tick();
    chk("R7 pulse ends", {7'd0, irq_o}, 8'h00);

    legacy_i = 1'b0;
    wr(8'h00); tick();
    chk("R11 newer variant write", {7'd0, irq_o}, 8'h00);
    tick();
    chk("R11 newer variant write", {7'd0, irq_o}, 8'h00);

    disp_en_i = 1'b0;
    wr(8'h78);
    line_i = 8'd9; cmp_i = 8'd9; mode_i = 2'd1;
    tick(); tick();
    chk("R10 display off irq", {7'd0, irq_o}, 8'h00);
    chk("R10 display off match", {7'd0, rd_data_o[2]}, 8'h00);
    disp_en_i = 1'b1; tick();
    chk("R10 display back on", {7'd0, irq_o}, 8'h01);

    wr(8'h40);
    mode_i = 2'd3; line_i = 8'd1; cmp_i = 8'd2;
    repeat (3) tick();
    cmp_i = 8'd1; tick();
    chk("R5 match not yet seen", {7'd0, irq_o}, 8'h00);
    tick();
    chk("R5 delayed match request", {7'd0, irq_o}, 8'h01);

    repeat (2) tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule